// File: doc/BRIEF.md
# Memory domain access checker

This block decides, during address translation, whether a memory access may proceed on the strength of the domain it belongs to. Each translation entry carries a 4-bit domain number. A 32-bit permission word holds a 2-bit policy code for each of sixteen domains. The block picks the code for the requested domain and applies one of four policies. Deny and reserved raise a domain fault. Client defers to the result of the page-table permission check. Manager grants the access without consulting the page-table permission bits.

When the long-descriptor translation format is selected, the domain mechanism is switched off. The verdict then comes from the page-table permission result alone.

The block has three outputs: a domain fault, a flag that the page-table permission bits were consulted, and the final grant. A parameter selects a registered output stage (default) or a purely combinational path. The four policy codes work as the decoder's named states:

- `POL_DENY` (00) leads to a fault.
- `POL_CLIENT` (01) leads to a deferred decision.
- `POL_RSVD` (10) leads to a fault.
- `POL_MGR` (11) leads to a bypass.

The long-format override is the one transition that leaves all four states unused.

Top module: `dom_access_check`

## Requirements
- R1: The policy code for domain n is taken from bits [2n+1:2n] of `perm_word`, with domain 0 in the least significant pair.
- R2: With `long_fmt` low and code 00 (deny), the result is `dom_fault`=1, `pt_check`=0 and `grant`=0, whatever `pt_ok` is.
- R3: With `long_fmt` low and code 01 (client), the result is `dom_fault`=0, `pt_check`=1 and `grant`=`pt_ok`.
- R4: With `long_fmt` low and code 11 (manager), the result is `dom_fault`=0, `pt_check`=0 and `grant`=1, whatever `pt_ok` is.
- R5: With `long_fmt` low and the reserved code 10, the result is the same as deny: `dom_fault`=1, `pt_check`=0 and `grant`=0.
- R6: With `long_fmt` high, the result is `dom_fault`=0, `pt_check`=1 and `grant`=`pt_ok`, whatever the code or the domain number is.
- R7: A domain fault takes priority over the permission result: `dom_fault` and `grant` are never high together, and `dom_fault` and `pt_check` are never high together.
- R8: With REG_OUT=1, the outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, all three outputs are 0.
- R9: The policy fields of domains other than the selected one have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| dom_sel | input | 4 | Domain number of the translation entry |
| perm_word | input | 32 | Sixteen 2-bit domain policy codes |
| long_fmt | input | 1 | Long-descriptor format selected; bypasses the domain check |
| pt_ok | input | 1 | Page-table permission check passed |
| dom_fault | output | 1 | Domain fault |
| pt_check | output | 1 | Page-table permission bits were consulted |
| grant | output | 1 | Access allowed |

## Verification
The only internal state is the output register together with the selected policy field feeding it. If the design picks the wrong field, the wrong policy shows up in the very next cycle's verdict. The sweep is built so that this mistake cannot hide. In every vector, each neighbouring field holds a code that yields a different verdict from the selected one.

A decoder that swaps two policies shows up as a wrong `grant` or `dom_fault` one clock after the vector is applied. A stale or unreset register shows up as non-zero outputs during reset, or as the previous vector's verdict being held one cycle too long.

// File: rtl/dom_access_pkg.sv
package dom_access_pkg;

    localparam int POL_W = 2;

    typedef enum logic [POL_W-1:0] {
        POL_DENY   = 2'b00,
        POL_CLIENT = 2'b01,
        POL_RSVD   = 2'b10,
        POL_MGR    = 2'b11
    } policy_e;

    typedef struct packed {
        logic dom_fault;
        logic pt_check;
        logic grant;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{dom_fault: 1'b0, pt_check: 1'b0, grant: 1'b0};

endpackage

// File: rtl/dom_field_select.sv
module dom_field_select
    import dom_access_pkg::*;
#(
    parameter int NUM_DOM = 16,
    localparam int SEL_W  = $clog2(NUM_DOM),
    localparam int WORD_W = NUM_DOM * POL_W
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] word,
    output policy_e           pol
);

    logic [POL_W-1:0] fields [NUM_DOM];

    for (genvar gi = 0; gi < NUM_DOM; gi++) begin : g_field
        assign fields[gi] = word[gi*POL_W +: POL_W];
    end

    assign pol = policy_e'(fields[sel]);

endmodule

// File: rtl/dom_policy_decode.sv
module dom_policy_decode
    import dom_access_pkg::*;
(
    input  policy_e  pol,
    input  logic     long_fmt,
    input  logic     pt_ok,
    output verdict_t verdict
);

    always_comb begin
        verdict = VERDICT_IDLE;
        if (long_fmt) begin
            // Domain mechanism off: page-table result alone
            verdict.pt_check = 1'b1;
            verdict.grant    = pt_ok;
        end else begin
            unique case (pol)
                POL_DENY, POL_RSVD: begin
                    verdict.dom_fault = 1'b1;
                end
                POL_CLIENT: begin
                    verdict.pt_check = 1'b1;
                    verdict.grant    = pt_ok;
                end
                POL_MGR: begin
                    verdict.grant = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/dom_out_stage.sv
module dom_out_stage
    import dom_access_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  verdict_t d,
    output verdict_t q
);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= VERDICT_IDLE;
            end else begin
                q <= d;
            end
        end
    end else begin : g_comb
        assign q = d;
    end

endmodule

// File: rtl/dom_access_check.sv
module dom_access_check
    import dom_access_pkg::*;
#(
    parameter int NUM_DOM = 16,
    parameter bit REG_OUT = 1'b1,
    localparam int SEL_W  = $clog2(NUM_DOM),
    localparam int WORD_W = NUM_DOM * POL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  dom_sel,
    input  logic [WORD_W-1:0] perm_word,
    input  logic              long_fmt,
    input  logic              pt_ok,
    output logic              dom_fault,
    output logic              pt_check,
    output logic              grant
);

    policy_e  pol;
    verdict_t verdict_d;
    verdict_t verdict_q;

    dom_field_select #(.NUM_DOM(NUM_DOM)) u_sel (
        .sel  (dom_sel),
        .word (perm_word),
        .pol  (pol)
    );

    dom_policy_decode u_dec (
        .pol      (pol),
        .long_fmt (long_fmt),
        .pt_ok    (pt_ok),
        .verdict  (verdict_d)
    );

    dom_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (verdict_d),
        .q     (verdict_q)
    );

    assign dom_fault = verdict_q.dom_fault;
    assign pt_check  = verdict_q.pt_check;
    assign grant     = verdict_q.grant;

endmodule

// File: rtl/dom_access_check_sva.sv
module dom_access_check_sva #(
    parameter int NUM_DOM = 16,
    parameter bit REG_OUT = 1'b1,
    localparam int SEL_W  = $clog2(NUM_DOM),
    localparam int WORD_W = NUM_DOM * 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  dom_sel,
    input logic [WORD_W-1:0] perm_word,
    input logic              long_fmt,
    input logic              pt_ok,
    input logic              dom_fault,
    input logic              pt_check,
    input logic              grant
);

    logic [SEL_W-1:0]  q_sel;
    logic [WORD_W-1:0] q_word;
    logic              q_long;
    logic              q_pt;
    logic              ok;
    logic [1:0]        q_code;

    if (REG_OUT) begin : g_lat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_sel  <= '0;
                q_word <= '0;
                q_long <= 1'b0;
                q_pt   <= 1'b0;
                ok     <= 1'b0;
            end else begin
                q_sel  <= dom_sel;
                q_word <= perm_word;
                q_long <= long_fmt;
                q_pt   <= pt_ok;
                ok     <= 1'b1;
            end
        end
    end else begin : g_now
        assign q_sel  = dom_sel;
        assign q_word = perm_word;
        assign q_long = long_fmt;
        assign q_pt   = pt_ok;
        assign ok     = 1'b1;
    end

    assign q_code = q_word[q_sel*2 +: 2];

    a_r2_deny_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !q_long && q_code == 2'b00) |-> (dom_fault && !grant && !pt_check));

    a_r3_client_defers: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !q_long && q_code == 2'b01) |-> (!dom_fault && pt_check && grant == q_pt));

    a_r4_manager_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !q_long && q_code == 2'b11) |-> (!dom_fault && !pt_check && grant));

    a_r5_reserved_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !q_long && q_code == 2'b10) |-> (dom_fault && !grant));

    a_r6_long_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && q_long) |-> (!dom_fault && pt_check && grant == q_pt));

    a_r7_single_fault: assert property (@(posedge clk) disable iff (!rst_n)
        dom_fault |-> (!grant && !pt_check));

    a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dom_fault, grant}));

endmodule

bind dom_access_check dom_access_check_sva #(
    .NUM_DOM (NUM_DOM),
    .REG_OUT (REG_OUT)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .dom_sel   (dom_sel),
    .perm_word (perm_word),
    .long_fmt  (long_fmt),
    .pt_ok     (pt_ok),
    .dom_fault (dom_fault),
    .pt_check  (pt_check),
    .grant     (grant)
);

// File: tb/sim_dom_access_check.sv
`timescale 1ns/1ps
module sim_dom_access_check;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  dom_sel = '0;
    logic [31:0] perm_word = '0;
    logic        long_fmt = 1'b0;
    logic        pt_ok = 1'b0;
    logic        dom_fault, pt_check, grant;

    int n_vec  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    dom_access_check u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .dom_sel   (dom_sel),
        .perm_word (perm_word),
        .long_fmt  (long_fmt),
        .pt_ok     (pt_ok),
        .dom_fault (dom_fault),
        .pt_check  (pt_check),
        .grant     (grant)
    );

    task automatic cmp(input string tag, input logic [2:0] exp);
        n_vec++;
        if ({dom_fault, pt_check, grant} !== exp) begin
            n_fail++;
            $display("FAIL %s: {dom_fault,pt_check,grant} actual=%b expected=%b (sel=%0d word=%h long=%b pt=%b)",
                     tag, {dom_fault, pt_check, grant}, exp, dom_sel, perm_word, long_fmt, pt_ok);
        end
        if (dom_fault && (grant || pt_check)) begin
            n_fail++;
            $display("FAIL R7: dom_fault with grant/pt_check actual=%b expected=100",
                     {dom_fault, pt_check, grant});
        end
    endtask

    // Expected verdict computed from the requirements
    function automatic logic [2:0] expect_of(input logic [1:0] code, input logic lf, input logic pk);
        if (lf)                return {1'b0, 1'b1, pk};  // R6
        else if (code == 2'b01) return {1'b0, 1'b1, pk};  // R3
        else if (code == 2'b11) return 3'b001;            // R4
        else                   return 3'b100;            // R2, R5
    endfunction

    function automatic string tag_of(input logic [1:0] code, input logic lf);
        if (lf) return "R6";
        case (code)
            2'b00:   return "R2 (field R1, neighbours R9)";
            2'b01:   return "R3 (field R1, neighbours R9)";
            2'b10:   return "R5 (field R1, neighbours R9)";
            default: return "R4 (field R1, neighbours R9)";
        endcase
    endfunction

    initial begin : watchdog
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : stim
        logic [31:0] w;
        // R8: outputs cleared while reset is held, even with a granting input
        perm_word = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        cmp("R8 reset", 3'b000);
        rst_n = 1'b1;

        // Sweep: every domain x every code x long_fmt x pt_ok x two neighbour patterns
        for (int bg = 0; bg < 2; bg++) begin
            for (int d = 0; d < 16; d++) begin
                for (int c = 0; c < 4; c++) begin
                    for (int lf = 0; lf < 2; lf++) begin
                        for (int pk = 0; pk < 2; pk++) begin
                            w = '0;
                            for (int k = 0; k < 16; k++) begin
                                // R9: neighbours hold codes with a different verdict
                                logic [1:0] nb;
                                nb = (bg == 0) ? (2'(c) ^ 2'b11) : ((c == 1) ? 2'b11 : 2'b01);
                                w[2*k +: 2] = (k == d) ? 2'(c) : nb;
                            end
                            @(negedge clk);
                            dom_sel   = 4'(d);
                            perm_word = w;
                            long_fmt  = 1'(lf);
                            pt_ok     = 1'(pk);
                            @(negedge clk);
                            cmp(tag_of(2'(c), 1'(lf)), expect_of(2'(c), 1'(lf), 1'(pk)));
                        end
                    end
                end
            end
        end

        // R8: one-cycle latency. Deny vector, then manager vector; output holds until the edge
        @(negedge clk);
        dom_sel = 4'd5; perm_word = 32'h0; long_fmt = 1'b0; pt_ok = 1'b1;
        @(negedge clk);
        cmp("R8 latency setup", 3'b100);
        perm_word = 32'h0000_0C00;          // domain 5 = manager
        #2;
        cmp("R8 held before edge", 3'b100);
        @(negedge clk);
        cmp("R8 after edge", 3'b001);

        // R8: asynchronous reset clears a granting output
        rst_n = 1'b0;
        #2;
        cmp("R8 async reset", 3'b000);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule